// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block keeps a two-entry instruction look-ahead filled for a 16-bit processor. It owns the fetch counter, which holds the address of the next word to fetch. It also owns three word registers: a look-ahead slot, an execute slot that holds the word being decoded, and an operand slot. Each completed memory fetch moves the counter forward by one. The returned word is placed according to which slots are empty. When the look-ahead slot is empty, the word goes there. When only the execute slot is empty, the look-ahead word moves down into it, and the new word is written into both the look-ahead slot and the operand slot.

The decoder reports whether the word in the execute slot needs a second word, either an immediate operand or the second half of a double-width instruction. When it does, the word just captured in the operand slot is that second word. One more fetch then refills only the look-ahead slot, and the operand slot keeps its value. A jump, branch or reset loads the counter and empties the queue. A word still in flight when a jump is taken is thrown away when it arrives. The counter value is always visible for subroutine and interrupt return linkage.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset (asynchronous, active low) the counter equals RESET_ADDR (default 0x0000), all slots are empty, `ready_o` is 0 and `fetch_req_o` is 1.
- R2: The counter advances by exactly one for each accepted fetch completion. While a request is pending with no completion, the address stays unchanged.
- R3: A flush loads the counter with `target_i` and empties every slot, so `ready_o` is 0 in the next cycle. Fetching then resumes at the target address.
- R4: A word fetched while the look-ahead slot is empty is stored there only, and `ready_o` stays 0.
- R5: A word fetched while the look-ahead slot is full and the execute slot is empty moves the look-ahead word to `instr_o` and writes the new word to the look-ahead slot and to `imm_o`. `ready_o` then rises.
- R6: While `exe_two_i` is 1 and the look-ahead slot still holds the executing word's operand, `fetch_req_o` is 1. The next fetch refills only the look-ahead slot, and `imm_o` keeps its value.
- R7: When the execute slot and the look-ahead slot both hold independent instructions (`exe_two_i` is 0), `fetch_req_o` is 0.
- R8: `consume_i` while `ready_o` is 1 empties the execute slot. If the retired instruction was two-word and its operand was still in the look-ahead slot, that slot is emptied too.
- R9: A flush while a fetch is pending (`fetch_req_o` 1, `fetch_done_i` 0) causes the next completion to be discarded without a counter step. `fetch_req_o` is held at 0 until that completion arrives.
- R10: A completion in the same cycle as a flush is discarded, and fetching at the target starts in the next cycle.
- R11: `link_o` always equals the counter, which is also `fetch_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Jump/branch: load counter and empty queue |
| target_i | input | AW | Jump/branch target address |
| fetch_req_o | output | 1 | A fetch is wanted at `fetch_addr_o` |
| fetch_addr_o | output | AW | Address of the word to fetch |
| fetch_done_i | input | 1 | Fetch completed; `fetch_data_i` valid |
| fetch_data_i | input | DW | Returned memory word |
| exe_two_i | input | 1 | Decoder: executing word needs a second word |
| consume_i | input | 1 | Decoder retires the executing instruction |
| ready_o | output | 1 | Execute slot (and operand, if needed) present |
| instr_o | output | DW | Executing instruction word |
| imm_o | output | DW | Operand / second-half word |
| link_o | output | AW | Counter value for return linkage |

## Verification
The assertions run on every cycle and check the counter arithmetic. The counter steps by one on each accepted word, holds its value otherwise, and takes the target on a flush. They also check that the pending address stays stable, that the request is silenced after a flush interrupts a pending fetch, that a shifting fetch lands in the operand slot, and that the operand is kept during a refill fetch. Slot routing over whole sequences can only be shown by the bench's scenarios. These cover the first, shifting and refill fetches; retiring with and without the operand still queued; a flush that collides with a completion; and a reset in mid-stream.

// File: rtl/ifq_pkg.sv
`timescale 1ns/1ps
package ifq_pkg;

  // Where an accepted fetch word is placed.
  typedef enum logic [1:0] {
    FILL_NONE  = 2'd0,
    FILL_FIRST = 2'd1,  // into the empty look-ahead slot
    FILL_SHIFT = 2'd2,  // look-ahead moves down, word to look-ahead + operand
    FILL_OPND  = 2'd3   // replace operand copy in look-ahead, operand kept
  } fill_e;

  function automatic fill_e ifq_route(input logic la_full,
                                      input logic ex_full,
                                      input logic la_is_opnd,
                                      input logic ex_two);
    if (!la_full)               return FILL_FIRST;
    if (!ex_full)               return FILL_SHIFT;
    if (la_is_opnd && ex_two)   return FILL_OPND;
    return FILL_NONE;
  endfunction

endpackage

// File: rtl/ifq_counter.sv
`timescale 1ns/1ps
module ifq_counter #(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] target_i,
  input  logic          fetch_done_i,
  input  logic          req_active_i,
  output logic [AW-1:0] ic_o,
  output logic          drop_o,
  output logic          accept_o
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + ONE;
  endfunction

  logic [AW-1:0] ic_q;
  logic          drop_q;

  // Completion that carries a word the queue keeps.
  assign accept_o = fetch_done_i && !drop_q && !flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q   <= RESET_ADDR;
      drop_q <= 1'b0;
    end else if (flush_i) begin
      ic_q   <= target_i;
      drop_q <= !fetch_done_i && (drop_q || req_active_i);
    end else if (fetch_done_i && drop_q) begin
      drop_q <= 1'b0;
    end else if (accept_o) begin
      ic_q   <= step_addr(ic_q);
    end
  end

  assign ic_o   = ic_q;
  assign drop_o = drop_q;

  // R2
  ic_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> ic_o == $past(ic_o) + ONE);

  // R2
  ic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_o && !flush_i) |=> $stable(ic_o));

  // R3
  ic_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ic_o == $past(target_i));

endmodule

// File: rtl/ifq_slots.sv
`timescale 1ns/1ps
module ifq_slots
  import ifq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          accept_i,
  input  logic [DW-1:0] word_i,
  input  logic          exe_two_i,
  input  logic          consume_i,
  output logic          need_o,
  output logic          ready_o,
  output logic [DW-1:0] instr_o,
  output logic [DW-1:0] imm_o
);

  logic [DW-1:0] la_q, ex_q, op_q;
  logic          la_v_q, ex_v_q, op_v_q, la_opnd_q;

  logic [DW-1:0] la_d, ex_d, op_d;
  logic          la_v_d, ex_v_d, op_v_d, la_opnd_d;

  // Named events for the checks.
  logic  retire;
  logic  post_la_v, post_ex_v, post_opnd;
  fill_e fill;

  assign ready_o = ex_v_q && (!exe_two_i || op_v_q);
  assign retire  = consume_i && ready_o && !flush_i;

  // Slot state after a retirement in this cycle.
  assign post_ex_v = ex_v_q && !retire;
  assign post_la_v = la_v_q && !(retire && exe_two_i && la_opnd_q);
  assign post_opnd = la_opnd_q && post_la_v;

  assign fill   = ifq_route(post_la_v, post_ex_v, post_opnd, exe_two_i);
  assign need_o = ifq_route(la_v_q, ex_v_q, la_opnd_q, exe_two_i) != FILL_NONE;

  always_comb begin
    la_d      = la_q;
    ex_d      = ex_q;
    op_d      = op_q;
    la_v_d    = post_la_v;
    ex_v_d    = post_ex_v;
    op_v_d    = op_v_q && !retire;
    la_opnd_d = post_opnd;
    if (accept_i) begin
      unique case (fill)
        FILL_FIRST: begin
          la_d      = word_i;
          la_v_d    = 1'b1;
          la_opnd_d = 1'b0;
        end
        FILL_SHIFT: begin
          ex_d      = la_q;
          ex_v_d    = 1'b1;
          la_d      = word_i;
          op_d      = word_i;
          op_v_d    = 1'b1;
          la_opnd_d = 1'b1;
        end
        FILL_OPND: begin
          la_d      = word_i;
          la_opnd_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (flush_i) begin
      la_v_d    = 1'b0;
      ex_v_d    = 1'b0;
      op_v_d    = 1'b0;
      la_opnd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_q      <= '0;
      ex_q      <= '0;
      op_q      <= '0;
      la_v_q    <= 1'b0;
      ex_v_q    <= 1'b0;
      op_v_q    <= 1'b0;
      la_opnd_q <= 1'b0;
    end else begin
      la_q      <= la_d;
      ex_q      <= ex_d;
      op_q      <= op_d;
      la_v_q    <= la_v_d;
      ex_v_q    <= ex_v_d;
      op_v_q    <= op_v_d;
      la_opnd_q <= la_opnd_d;
    end
  end

  assign instr_o = ex_q;
  assign imm_o   = op_q;

  // R5
  shift_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && fill == FILL_SHIFT) |=> ex_v_q && imm_o == $past(word_i));

  // R6
  opnd_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && fill == FILL_OPND) |=> $stable(imm_o));

  // R3
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !ready_o);

endmodule

// File: rtl/instr_prefetch_queue.sv
`timescale 1ns/1ps
module instr_prefetch_queue #(
  parameter int            AW         = 16,
  parameter int            DW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] target_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_done_i,
  input  logic [DW-1:0] fetch_data_i,
  input  logic          exe_two_i,
  input  logic          consume_i,
  output logic          ready_o,
  output logic [DW-1:0] instr_o,
  output logic [DW-1:0] imm_o,
  output logic [AW-1:0] link_o
);

  logic [AW-1:0] ic;
  logic          drop;
  logic          accept;
  logic          need;

  assign fetch_req_o = need && !drop;

  ifq_counter #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .target_i     (target_i),
    .fetch_done_i (fetch_done_i),
    .req_active_i (fetch_req_o),
    .ic_o         (ic),
    .drop_o       (drop),
    .accept_o     (accept)
  );

  ifq_slots #(.DW(DW)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .accept_i  (accept),
    .word_i    (fetch_data_i),
    .exe_two_i (exe_two_i),
    .consume_i (consume_i),
    .need_o    (need),
    .ready_o   (ready_o),
    .instr_o   (instr_o),
    .imm_o     (imm_o)
  );

  assign fetch_addr_o = ic;
  assign link_o       = ic;

  // R9
  stale_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && fetch_req_o && !fetch_done_i) |=> !fetch_req_o);

  // R2
  pending_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_o && !fetch_done_i && !flush_i) |=> $stable(fetch_addr_o));

endmodule

// File: tb/instr_prefetch_queue_bench.sv
`timescale 1ns/1ps
module instr_prefetch_queue_bench;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic [AW-1:0] target_i = '0;
  logic          fetch_done_i = 1'b0;
  logic [DW-1:0] fetch_data_i = '0;
  logic          exe_two_i = 1'b0;
  logic          consume_i = 1'b0;
  logic          fetch_req_o, ready_o;
  logic [AW-1:0] fetch_addr_o, link_o;
  logic [DW-1:0] instr_o, imm_o;

  always #2 clk = ~clk;

  instr_prefetch_queue u_instr_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .target_i(target_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_done_i(fetch_done_i), .fetch_data_i(fetch_data_i),
    .exe_two_i(exe_two_i), .consume_i(consume_i), .ready_o(ready_o),
    .instr_o(instr_o), .imm_o(imm_o), .link_o(link_o)
  );

  typedef struct packed {
    logic        fl;
    logic [15:0] tgt;
    logic        dn;
    logic [15:0] dat;
    logic        lg;
    logic        cs;
    logic        req;
    logic [15:0] addr;
    logic        rdy;
    logic [15:0] ins;
    logic [15:0] imm;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0,16'h0000,1'b1,16'hA001,1'b0,1'b0, 1'b1,16'h0001,1'b0,16'h0000,16'h0000,4'd4},  // R4 first word
    '{1'b0,16'h0000,1'b1,16'hA002,1'b0,1'b0, 1'b0,16'h0002,1'b1,16'hA001,16'hA002,4'd5},  // R5 shift
    '{1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0, 1'b0,16'h0002,1'b1,16'hA001,16'hA002,4'd7},  // R7 full, quiet
    '{1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1, 1'b1,16'h0002,1'b0,16'h0000,16'h0000,4'd8},  // R8 retire short
    '{1'b0,16'h0000,1'b1,16'hB003,1'b1,1'b0, 1'b1,16'h0003,1'b1,16'hA002,16'hB003,4'd5},  // R5 shift, two-word
    '{1'b0,16'h0000,1'b1,16'hC004,1'b1,1'b0, 1'b0,16'h0004,1'b1,16'hA002,16'hB003,4'd6},  // R6 refill, operand kept
    '{1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b1, 1'b1,16'h0004,1'b0,16'h0000,16'h0000,4'd8},  // R8 retire after refill
    '{1'b0,16'h0000,1'b1,16'hD005,1'b1,1'b0, 1'b1,16'h0005,1'b1,16'hC004,16'hD005,4'd6},  // R6 operand queued, req
    '{1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b1, 1'b1,16'h0005,1'b0,16'h0000,16'h0000,4'd8},  // R8 retire drops operand
    '{1'b0,16'h0000,1'b1,16'hE006,1'b0,1'b0, 1'b1,16'h0006,1'b0,16'h0000,16'h0000,4'd4},  // R4 first into empty
    '{1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0, 1'b1,16'h0006,1'b0,16'h0000,16'h0000,4'd2},  // R2 stall holds
    '{1'b1,16'h2000,1'b1,16'hFFFF,1'b0,1'b0, 1'b1,16'h2000,1'b0,16'h0000,16'h0000,4'd10}, // R10 collide
    '{1'b0,16'h0000,1'b1,16'h1111,1'b0,1'b0, 1'b1,16'h2001,1'b0,16'h0000,16'h0000,4'd2},  // R2 step
    '{1'b1,16'h3000,1'b0,16'h0000,1'b0,1'b0, 1'b0,16'h3000,1'b0,16'h0000,16'h0000,4'd9},  // R9 flush pending
    '{1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0, 1'b0,16'h3000,1'b0,16'h0000,16'h0000,4'd9},  // R9 muted
    '{1'b0,16'h0000,1'b1,16'hDEAD,1'b0,1'b0, 1'b1,16'h3000,1'b0,16'h0000,16'h0000,4'd9},  // R9 stale dropped
    '{1'b0,16'h0000,1'b1,16'h3AAA,1'b0,1'b0, 1'b1,16'h3001,1'b0,16'h0000,16'h0000,4'd3},  // R3 resume at target
    '{1'b0,16'h0000,1'b1,16'h3BBB,1'b0,1'b0, 1'b0,16'h3002,1'b1,16'h3AAA,16'h3BBB,4'd5},  // R5
    '{1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1, 1'b1,16'h3002,1'b0,16'h0000,16'h0000,4'd8},  // R8
    '{1'b0,16'h0000,1'b1,16'h3CCC,1'b0,1'b0, 1'b0,16'h3003,1'b1,16'h3BBB,16'h3CCC,4'd5}   // R5
  };

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  task automatic chk(input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input logic fl, input logic [15:0] tgt, input logic dn,
                      input logic [15:0] dat, input logic lg, input logic cs);
    @(negedge clk);
    flush_i = fl; target_i = tgt; fetch_done_i = dn;
    fetch_data_i = dat; exe_two_i = lg; consume_i = cs;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(1, "req", fetch_req_o, 1);
    chk(1, "addr", fetch_addr_o, 16'h0000);
    chk(1, "ready", ready_o, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      step(v.fl, v.tgt, v.dn, v.dat, v.lg, v.cs);
      chk(v.rq, "req", fetch_req_o, v.req);
      chk(v.rq, "addr", fetch_addr_o, v.addr);
      chk(v.rq, "ready", ready_o, v.rdy);
      chk(11, "link", link_o, v.addr);  // R11
      if (v.rdy) begin
        chk(v.rq, "instr", instr_o, v.ins);
        chk(v.rq, "imm", imm_o, v.imm);
      end
    end

    // R1 reset in mid-stream empties the queue
    @(negedge clk);
    flush_i = 1'b0; fetch_done_i = 1'b0; consume_i = 1'b0; exe_two_i = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk(1, "req", fetch_req_o, 1);
    chk(1, "addr", fetch_addr_o, 16'h0000);
    chk(1, "ready", ready_o, 0);
    chk(11, "link", link_o, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    // R6 two-word instruction: stalled refill keeps the operand
    step(1'b0, 16'h0, 1'b1, 16'h5A01, 1'b1, 1'b0);
    step(1'b0, 16'h0, 1'b1, 16'h5B02, 1'b1, 1'b0);
    step(1'b0, 16'h0, 1'b0, 16'h0000, 1'b1, 1'b0);
    chk(6, "req", fetch_req_o, 1);
    chk(6, "addr", fetch_addr_o, 16'h0002);
    chk(6, "ready", ready_o, 1);
    chk(6, "instr", instr_o, 16'h5A01);
    chk(6, "imm", imm_o, 16'h5B02);
    step(1'b0, 16'h0, 1'b1, 16'h5C03, 1'b1, 1'b0);
    chk(6, "imm", imm_o, 16'h5B02);
    chk(6, "req", fetch_req_o, 0);

    report();
  end

endmodule